// File: doc/BRIEF.md
# CAN Error Flag and Interrupt Unit

This block sits beside a CAN protocol engine and turns its one-cycle event pulses into software-visible state. Eight error event kinds (bus error, error warning, error passive, bus-off entry, bus-off recovery, receive overrun, overload frame, bus lock) are recorded as sticky flags, each admitted only while its enable bit is set. A separate code store records which kind of bus error occurred. Depending on its mode bit, the store either gathers every code seen until software clears it or shows only the most recent error.

The enabled error flags are summarised into one bit of an interrupt status register. That register also holds two sticky bits for receive-FIFO and transmit-FIFO events. Each status bit is masked by an interrupt enable bit, and the masked bits are ORed into one interrupt request line. Software reaches all registers through a byte-wide register port. Write data takes effect on the clock edge and is visible on the combinational read port one cycle later. Every sticky bit clears only where a 0 is written. A bit written with 1 keeps its value. An event that arrives in the same cycle as a clearing write wins.

Top module: `can_err_irq_unit`

## Requirements
- R1: After reset every register reads 0x00 and `irq` is low. The register addresses are: 0 error flags, 1 error enables, 2 code store, 3 interrupt status, 4 interrupt enables.
- R2: A pulse on `err_evt[i]` while error-enable bit i is 1 sets error-flag bit i on the next clock edge. The bit order from 7 down to 0 is: bus lock, overload frame, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error.
- R3: A pulse on `err_evt[i]` while error-enable bit i is 0 leaves error-flag bit i at 0.
- R4: Writing 0 to an error-flag bit clears it. Writing 1 leaves it unchanged.
- R5: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: With code-store bit 7 (mode) at 1, a pulse on `code_evt` ORs into code-store bits 6:0. The code bits from 6 down to 0 are: ACK delimiter, bit error dominant, bit error recessive, CRC, ACK, form, stuff.
- R7: With the mode bit at 0, a non-zero `code_evt` replaces code-store bits 6:0 with exactly the new code.
- R8: Code-store bits 6:0 clear only where 0 is written. Bit 7 is a plain read/write mode bit.
- R9: Interrupt-status bit 5 reads 1 exactly while some error flag is 1 together with its enable. Writes to this bit have no effect.
- R10: `rxf_evt` sets interrupt-status bit 4 and `txf_evt` sets bit 3. Both clear by writing 0. The other status bits read 0.
- R11: `irq` is high exactly while a status bit at position 5, 4 or 3 is 1 together with the interrupt-enable bit at the same position. The interrupt-enable register holds only bits 5, 4 and 3; its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| err_evt | input | 8 | Error event pulses, one per error-flag bit |
| code_evt | input | 7 | Bus error code pulses, one per code-store bit 6:0 |
| rxf_evt | input | 1 | Receive FIFO event pulse |
| txf_evt | input | 1 | Transmit FIFO event pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that event inputs come from a synchronous protocol engine and are never unknown once reset is released. The bench holds every event input at 0 from time zero and raises it for exactly one clock. The assertions also assume that a register write lasts one cycle and targets a defined address. The bench drives each write for a single cycle, placed between clock edges, so every write and every event lands on one known edge. Collisions between an event and a clearing write are produced on purpose, only in the scenario that checks R5.

// File: rtl/can_eiu_pkg.sv
package can_eiu_pkg;
  localparam int ERR_W  = 8;
  localparam int CODE_W = 7;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam int A_ERRFLAG = 0;
  localparam int A_ERREN   = 1;
  localparam int A_CODE    = 2;
  localparam int A_IRQST   = 3;
  localparam int A_IRQEN   = 4;

  localparam int IRQ_ERR_BIT = 5;
  localparam int IRQ_RX_BIT  = 4;
  localparam int IRQ_TX_BIT  = 3;
  localparam int N_IRQ       = 3;
endpackage

// File: rtl/can_flag_bank.sv
module can_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_comb begin
        q_d[i] = q_q[i];
        if (wr_i && !wdata_i[i]) q_d[i] = 1'b0;
        if (set_i[i])            q_d[i] = 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R2 R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_q & $past(set_i)) == $past(set_i)));

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && !wr_i) |=> $stable(q_q));
endmodule

// File: rtl/can_code_store.sv
module can_code_store #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] code_i,
  input  logic          wr_i,
  input  logic [CW:0]   wdata_i,
  output logic [CW:0]   q_o
);
  logic          mode_q, mode_d;
  logic [CW-1:0] code_q, code_d, kept;

  always_comb begin
    mode_d = wr_i ? wdata_i[CW] : mode_q;
    kept   = wr_i ? (code_q & wdata_i[CW-1:0]) : code_q;
    if (mode_q)             code_d = kept | code_i;
    else if (code_i != '0)  code_d = code_i;
    else                    code_d = kept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      code_q <= '0;
    end else begin
      mode_q <= mode_d;
      code_q <= code_d;
    end
  end

  assign q_o = {mode_q, code_q};

  // R7
  latest_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && code_i != '0) |=> (code_q == $past(code_i)));

  // R6
  accumulate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && code_i != '0) |=> ((code_q & $past(code_i)) == $past(code_i)));
endmodule

// File: rtl/can_err_irq_unit.sv
module can_err_irq_unit
  import can_eiu_pkg::*;
#(
  parameter int ADDR_W = can_eiu_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [ERR_W-1:0]  err_evt,
  input  logic [CODE_W-1:0] code_evt,
  input  logic              rxf_evt,
  input  logic              txf_evt,
  output logic              irq
);
  logic wr_flag, wr_een, wr_code, wr_ist, wr_ien;
  logic [ERR_W-1:0]  eflag_q, een_q, een_d;
  logic [CODE_W:0]   code_q;
  logic [1:0]        fifo_q;
  logic [N_IRQ-1:0]  ien_q, ien_d, ist;
  logic              err_sum;

  assign wr_flag = reg_we && (reg_addr == ADDR_W'(A_ERRFLAG));
  assign wr_een  = reg_we && (reg_addr == ADDR_W'(A_ERREN));
  assign wr_code = reg_we && (reg_addr == ADDR_W'(A_CODE));
  assign wr_ist  = reg_we && (reg_addr == ADDR_W'(A_IRQST));
  assign wr_ien  = reg_we && (reg_addr == ADDR_W'(A_IRQEN));

  can_flag_bank #(.W(ERR_W)) u_err_flags (
    .clk(clk), .rst_n(rst_n), .set_i(err_evt & een_q),
    .wr_i(wr_flag), .wdata_i(reg_wdata), .q_o(eflag_q));

  can_flag_bank #(.W(2)) u_fifo_flags (
    .clk(clk), .rst_n(rst_n), .set_i({rxf_evt, txf_evt}),
    .wr_i(wr_ist), .wdata_i({reg_wdata[IRQ_RX_BIT], reg_wdata[IRQ_TX_BIT]}),
    .q_o(fifo_q));

  can_code_store #(.CW(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .code_i(code_evt),
    .wr_i(wr_code), .wdata_i(reg_wdata), .q_o(code_q));

  always_comb begin
    een_d = wr_een ? reg_wdata : een_q;
    ien_d = wr_ien ? {reg_wdata[IRQ_ERR_BIT], reg_wdata[IRQ_RX_BIT],
                      reg_wdata[IRQ_TX_BIT]} : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      een_q <= '0;
      ien_q <= '0;
    end else begin
      een_q <= een_d;
      ien_q <= ien_d;
    end
  end

  assign err_sum = |(eflag_q & een_q);
  assign ist     = {err_sum, fifo_q};
  assign irq     = |(ist & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (int'(reg_addr))
      A_ERRFLAG: reg_rdata = eflag_q;
      A_ERREN:   reg_rdata = een_q;
      A_CODE:    reg_rdata = code_q;
      A_IRQST: begin
        reg_rdata[IRQ_ERR_BIT] = ist[2];
        reg_rdata[IRQ_RX_BIT]  = ist[1];
        reg_rdata[IRQ_TX_BIT]  = ist[0];
      end
      A_IRQEN: begin
        reg_rdata[IRQ_ERR_BIT] = ien_q[2];
        reg_rdata[IRQ_RX_BIT]  = ien_q[1];
        reg_rdata[IRQ_TX_BIT]  = ien_q[0];
      end
      default: reg_rdata = '0;
    endcase
  end

  // R3
  gated_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_evt & ~een_q & ~eflag_q) != '0) |=>
      ((eflag_q & $past(err_evt & ~een_q & ~eflag_q)) == '0));

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

// File: tb/can_err_irq_unit_tb.sv
module can_err_irq_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] err_evt = '0;
  logic [6:0] code_evt = '0;
  logic       rxf_evt = 1'b0;
  logic       txf_evt = 1'b0;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  can_err_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_evt(err_evt),
    .code_evt(code_evt), .rxf_evt(rxf_evt), .txf_evt(txf_evt), .irq(irq));

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e, input logic [6:0] c,
                       input logic rx, input logic tx);
    @(negedge clk); err_evt = e; code_evt = c; rxf_evt = rx; txf_evt = tx;
    @(negedge clk); err_evt = '0; code_evt = '0; rxf_evt = 1'b0; txf_evt = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a,
                         input logic [7:0] exp);
    reg_addr = a; #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %0d: actual %02h expected %02h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input string req, input logic exp);
    #1; checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq: actual %b expected %b", req, irq, exp);
    end
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) chk_reg("R1", 3'(a), 8'h00);
    chk_irq("R1", 1'b0);
  endtask

  task automatic t_gate; // R3
    pulse(8'hFF, '0, 0, 0);
    chk_reg("R3", 3'd0, 8'h00);
    chk_reg("R3", 3'd3, 8'h00);
  endtask

  task automatic t_set; // R2
    wr(3'd1, 8'hFF);
    pulse(8'h08, '0, 0, 0);
    chk_reg("R2", 3'd0, 8'h08);
    pulse(8'h81, '0, 0, 0);
    chk_reg("R2", 3'd0, 8'h89);
  endtask

  task automatic t_clear; // R4
    wr(3'd0, 8'hF7);
    chk_reg("R4", 3'd0, 8'h81);
    wr(3'd0, 8'hFF);
    chk_reg("R4", 3'd0, 8'h81);
    wr(3'd0, 8'h00);
    chk_reg("R4", 3'd0, 8'h00);
  endtask

  task automatic t_collide; // R5
    pulse(8'h02, '0, 0, 0);
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00; err_evt = 8'h02;
    @(negedge clk); reg_we = 1'b0; err_evt = '0;
    chk_reg("R5", 3'd0, 8'h02);
    wr(3'd0, 8'h00);
    chk_reg("R5", 3'd0, 8'h00);
  endtask

  task automatic t_accum; // R6
    wr(3'd2, 8'h80);
    pulse('0, 7'h10, 0, 0);
    chk_reg("R6", 3'd2, 8'h90);
    pulse('0, 7'h01, 0, 0);
    chk_reg("R6", 3'd2, 8'h91);
  endtask

  task automatic t_code_clear; // R8
    wr(3'd2, 8'hEF);
    chk_reg("R8", 3'd2, 8'h81);
    wr(3'd2, 8'h7F);
    chk_reg("R8", 3'd2, 8'h01);
  endtask

  task automatic t_latest; // R7
    pulse('0, 7'h20, 0, 0);
    chk_reg("R7", 3'd2, 8'h20);
    pulse('0, 7'h44, 0, 0);
    chk_reg("R7", 3'd2, 8'h44);
  endtask

  task automatic t_summary; // R9
    pulse(8'h04, '0, 0, 0);
    chk_reg("R9", 3'd3, 8'h20);
    wr(3'd1, 8'h00);
    chk_reg("R9", 3'd3, 8'h00);
    chk_reg("R9", 3'd0, 8'h04);
    wr(3'd1, 8'hFF);
    wr(3'd3, 8'h00);
    chk_reg("R9", 3'd3, 8'h20);
    wr(3'd0, 8'h00);
    chk_reg("R9", 3'd3, 8'h00);
  endtask

  task automatic t_fifo; // R10
    pulse('0, '0, 1, 0);
    chk_reg("R10", 3'd3, 8'h10);
    pulse('0, '0, 0, 1);
    chk_reg("R10", 3'd3, 8'h18);
    wr(3'd3, 8'hEF);
    chk_reg("R10", 3'd3, 8'h08);
    wr(3'd3, 8'h00);
    chk_reg("R10", 3'd3, 8'h00);
  endtask

  task automatic t_irq; // R11
    pulse('0, '0, 1, 0);
    chk_irq("R11", 1'b0);
    wr(3'd4, 8'h10);
    chk_irq("R11", 1'b1);
    wr(3'd4, 8'hFF);
    chk_reg("R11", 3'd4, 8'h38);
    wr(3'd4, 8'h08);
    chk_irq("R11", 1'b0);
    wr(3'd3, 8'h00);
    pulse(8'h01, '0, 0, 0);
    wr(3'd4, 8'h20);
    chk_irq("R11", 1'b1);
    wr(3'd0, 8'h00);
    chk_irq("R11", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gate();
    t_set();
    t_clear();
    t_collide();
    t_accum();
    t_code_clear();
    t_latest();
    t_summary();
    t_fifo();
    t_irq();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule